// File: doc/BRIEF.md
# Three-Slot Issue Structural-Hazard Gate

This block sits in the issue stage of a three-wide in-order pipeline and decides, within the same cycle, which of the presented instruction slots may issue. Each slot carries a valid bit and a class code. The block grants the longest run of slots, starting from the oldest, whose functional resources are all free. For every granted slot it also reports the number of cycles until that slot's result can be consumed.

The resources that are tracked within one cycle are the single memory port, the two integer write ports, the single shifter and the FP adder. A shared iterative unit for multiply, divide and square root is also tracked, and it can stay busy across cycles. Integer multiply runs on that shared unit as well. The shared unit's busy state is a down-counter that is loaded at issue. Operand dependencies and the datapaths themselves are outside this block.

Top module: `issue_hazard_gate`

## Requirements
- R1: While the synchronous reset `rst` is high, no slot is granted. The reset clears the shared unit's busy state, so a square root in slot 0 on the first cycle after reset is granted.
- R2: Grants form an in-order prefix. If a slot is invalid or cannot get its resources, that slot is not granted and no younger slot in the same cycle is granted either.
- R3: At most one memory operation is granted per cycle. The memory operations are load (code 2), store (code 3), FP load (code 4) and FP store (code 5).
- R4: At most two granted slots per cycle use an integer write port. The classes that use one are integer ALU (code 0), shift (code 1), load (code 2) and store (code 3).
- R5: At most one shift (code 1) is granted per cycle.
- R6: At most one FP add/move/compare (code 6) is granted per cycle. It holds the FP adder for that cycle only.
- R7: The shared unit accepts at most one new operation per cycle, and only when it is idle. It then stays busy for the class's occupancy: FP multiply (code 7) 1 cycle, single divide (code 8) 4, double divide (code 9) 7, square root (code 10) 10, integer multiply (code 11) 4. The next shared operation can be granted exactly that many cycles after the issue.
- R8: For each granted slot, the latency output gives the class's result delay: 1 for codes 0, 1, 2, 3 and 5; 0 for code 4; 3 for codes 6 and 7; 6 for code 8; 9 for code 9; 12 for code 10; 4 for code 11.
- R9: The latency field of a slot that is not granted reads 0.
- R10: Codes 12 to 15 need no resource and are always granted when valid and reached in order. Their latency is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_vld | input | 3 | Valid bit per slot; bit 0 is the oldest slot |
| slot_cls | input | 12 | Class code per slot, 4 bits each; slot i uses bits [4i+3:4i] |
| grant | output | 3 | Per-slot issue grant, combinational in the same cycle |
| lat | output | 12 | Per-slot result latency, 4 bits each, same layout as slot_cls |

## Verification
Grants and latencies are combinational, so each is due in the same cycle the slots are presented. The shared unit's busy state changes only at the clock edge that follows a granted shared operation. The bench drives the slots just after a rising edge and compares both outputs at the falling edge of that same cycle. A behavioural model keeps the absolute cycle at which the shared unit becomes free again, and it advances only after that comparison, so each edge of the design is matched by exactly one model update. Directed sequences probe each resource limit and every shared-unit occupancy window by counting refused cycles. Random class mixes then replay against the same model.

// File: rtl/ihg_pkg.sv
package ihg_pkg;

    localparam int CLS_W = 4;
    localparam int LAT_W = 4;
    localparam int OCC_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CL_IALU  = 4'd0,
        CL_SHIFT = 4'd1,
        CL_LOAD  = 4'd2,
        CL_STORE = 4'd3,
        CL_FPLD  = 4'd4,
        CL_FPST  = 4'd5,
        CL_FPALU = 4'd6,
        CL_FPMUL = 4'd7,
        CL_FDIVS = 4'd8,
        CL_FDIVD = 4'd9,
        CL_FSQRT = 4'd10,
        CL_IMUL  = 4'd11
    } op_class_e;

    // Resources a slot needs in its issue cycle.
    typedef struct packed {
        logic             mem;
        logic             wport;
        logic             shift;
        logic             fpalu;
        logic             shared;
        logic [OCC_W-1:0] occ;
    } need_t;

endpackage

// File: rtl/ihg_class_decode.sv
module ihg_class_decode
    import ihg_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output need_t            need,
    output logic [LAT_W-1:0] lat
);

    always_comb begin
        need = '0;
        lat  = '0;
        case (cls)
            CL_IALU:  begin need.wport = 1'b1; lat = LAT_W'(1); end
            CL_SHIFT: begin need.wport = 1'b1; need.shift = 1'b1; lat = LAT_W'(1); end
            CL_LOAD:  begin need.wport = 1'b1; need.mem = 1'b1; lat = LAT_W'(1); end
            CL_STORE: begin need.wport = 1'b1; need.mem = 1'b1; lat = LAT_W'(1); end
            CL_FPLD:  begin need.mem = 1'b1; lat = LAT_W'(0); end
            CL_FPST:  begin need.mem = 1'b1; lat = LAT_W'(1); end
            CL_FPALU: begin need.fpalu = 1'b1; lat = LAT_W'(3); end
            CL_FPMUL: begin need.shared = 1'b1; need.occ = OCC_W'(1); lat = LAT_W'(3); end
            CL_FDIVS: begin need.shared = 1'b1; need.occ = OCC_W'(4); lat = LAT_W'(6); end
            CL_FDIVD: begin need.shared = 1'b1; need.occ = OCC_W'(7); lat = LAT_W'(9); end
            CL_FSQRT: begin need.shared = 1'b1; need.occ = OCC_W'(10); lat = LAT_W'(12); end
            CL_IMUL:  begin need.shared = 1'b1; need.occ = OCC_W'(4); lat = LAT_W'(4); end
            default:  begin need = '0; lat = '0; end  // R10: no resource, latency 0
        endcase
    end

endmodule

// File: rtl/ihg_shared_busy.sv
module ihg_shared_busy
    import ihg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OCC_W-1:0] occ,
    output logic             free
);

    typedef struct packed {
        logic [OCC_W-1:0] cnt;
    } busy_st_t;

    busy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = occ - OCC_W'(1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - OCC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free = (st_q.cnt == '0);

    // R7: a new user only enters an idle unit.
    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> free);

    // R7: occupancy is loaded at issue.
    a_r7_load_occ: assert property (@(posedge clk) disable iff (rst)
        start |=> (st_q.cnt == $past(occ) - OCC_W'(1)));

    // R7: busy time drains by one per cycle.
    a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
        (!start && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - OCC_W'(1)));

endmodule

// File: rtl/ihg_grant_chain.sv
module ihg_grant_chain
    import ihg_pkg::*;
#(
    parameter int SLOTS       = 3,
    parameter int MEM_PORTS   = 1,
    parameter int WR_PORTS    = 2,
    parameter int SHIFT_UNITS = 1,
    parameter int FPALU_UNITS = 1
) (
    input  logic             hold,
    input  logic [SLOTS-1:0] vld,
    input  need_t            need [SLOTS],
    input  logic             shared_free,
    output logic [SLOTS-1:0] grant,
    output logic             shared_start,
    output logic [OCC_W-1:0] shared_occ
);

    always_comb begin
        int   n_mem;
        int   n_wp;
        int   n_sh;
        int   n_fa;
        int   n_md;
        logic alive;
        logic fits;
        grant        = '0;
        shared_start = 1'b0;
        shared_occ   = '0;
        n_mem = 0;
        n_wp  = 0;
        n_sh  = 0;
        n_fa  = 0;
        n_md  = 0;
        alive = !hold;
        for (int i = 0; i < SLOTS; i++) begin
            fits = alive && vld[i];
            if (need[i].mem   && n_mem >= MEM_PORTS)   fits = 1'b0;
            if (need[i].wport && n_wp  >= WR_PORTS)    fits = 1'b0;
            if (need[i].shift && n_sh  >= SHIFT_UNITS) fits = 1'b0;
            if (need[i].fpalu && n_fa  >= FPALU_UNITS) fits = 1'b0;
            if (need[i].shared && (!shared_free || n_md != 0)) fits = 1'b0;
            if (fits) begin
                grant[i] = 1'b1;
                if (need[i].mem)   n_mem = n_mem + 1;
                if (need[i].wport) n_wp  = n_wp + 1;
                if (need[i].shift) n_sh  = n_sh + 1;
                if (need[i].fpalu) n_fa  = n_fa + 1;
                if (need[i].shared) begin
                    n_md         = n_md + 1;
                    shared_start = 1'b1;
                    shared_occ   = need[i].occ;
                end
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/issue_hazard_gate.sv
module issue_hazard_gate
    import ihg_pkg::*;
#(
    parameter int SLOTS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SLOTS-1:0]       slot_vld,
    input  logic [SLOTS*CLS_W-1:0] slot_cls,
    output logic [SLOTS-1:0]       grant,
    output logic [SLOTS*LAT_W-1:0] lat
);

    need_t            need   [SLOTS];
    logic [LAT_W-1:0] raw_lat [SLOTS];
    logic             shared_free;
    logic             shared_start;
    logic [OCC_W-1:0] shared_occ;

    logic [SLOTS-1:0] g_mem, g_wp, g_sh, g_fa, g_md;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        ihg_class_decode dec_i (
            .cls  (slot_cls[i*CLS_W +: CLS_W]),
            .need (need[i]),
            .lat  (raw_lat[i])
        );
        assign lat[i*LAT_W +: LAT_W] = grant[i] ? raw_lat[i] : '0;
        assign g_mem[i] = grant[i] & need[i].mem;
        assign g_wp[i]  = grant[i] & need[i].wport;
        assign g_sh[i]  = grant[i] & need[i].shift;
        assign g_fa[i]  = grant[i] & need[i].fpalu;
        assign g_md[i]  = grant[i] & need[i].shared;
    end

    ihg_grant_chain #(.SLOTS(SLOTS)) chain_i (
        .hold         (rst),
        .vld          (slot_vld),
        .need         (need),
        .shared_free  (shared_free),
        .grant        (grant),
        .shared_start (shared_start),
        .shared_occ   (shared_occ)
    );

    ihg_shared_busy busy_i (
        .clk   (clk),
        .rst   (rst),
        .start (shared_start),
        .occ   (shared_occ),
        .free  (shared_free)
    );

    a_r1_hold_in_reset: assert property (@(posedge clk) rst |-> (grant == '0));

    a_r2_in_order_prefix: assert property (@(posedge clk) disable iff (rst)
        (grant & (grant + 1'b1)) == '0);

    a_r2_valid_only: assert property (@(posedge clk) disable iff (rst)
        (grant & ~slot_vld) == '0);

    a_r3_one_mem: assert property (@(posedge clk) disable iff (rst)
        $countones(g_mem) <= 1);

    a_r4_two_wports: assert property (@(posedge clk) disable iff (rst)
        $countones(g_wp) <= 2);

    a_r5_one_shift: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g_sh));

    a_r6_one_fpalu: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g_fa));

    a_r7_one_shared: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g_md));

    // R7: a shared op issued last cycle with occupancy above one blocks this cycle.
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (shared_start && shared_occ > OCC_W'(1)) |=> (g_md == '0));

endmodule

// File: tb/issue_hazard_gate_tb_top.sv
`timescale 1ns/1ps
module issue_hazard_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  slot_vld = '0;
    logic [11:0] slot_cls = '0;
    logic [2:0]  grant;
    logic [11:0] lat;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int free_at = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    issue_hazard_gate dut_i (
        .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_cls(slot_cls),
        .grant(grant), .lat(lat)
    );

    function automatic void cls_info(input int c, output bit mem, output bit wp,
                                     output bit sh, output bit fa, output bit md,
                                     output int occ, output int l);
        mem = 0; wp = 0; sh = 0; fa = 0; md = 0; occ = 0; l = 0;
        case (c)
            0:  begin wp = 1; l = 1; end
            1:  begin wp = 1; sh = 1; l = 1; end
            2:  begin wp = 1; mem = 1; l = 1; end
            3:  begin wp = 1; mem = 1; l = 1; end
            4:  begin mem = 1; l = 0; end
            5:  begin mem = 1; l = 1; end
            6:  begin fa = 1; l = 3; end
            7:  begin md = 1; occ = 1;  l = 3; end
            8:  begin md = 1; occ = 4;  l = 6; end
            9:  begin md = 1; occ = 7;  l = 9; end
            10: begin md = 1; occ = 10; l = 12; end
            11: begin md = 1; occ = 4;  l = 4; end
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input string tag, input bit r, input bit [2:0] v,
                        input int c0, input int c1, input int c2);
        int cs[3];
        bit [2:0]  eg;
        bit [11:0] el;
        bit alive;
        int nm, nw, ns, nf, nd, md_occ;
        cs[0] = c0; cs[1] = c1; cs[2] = c2;
        @(posedge clk);
        #1;
        rst      = r;
        slot_vld = v;
        slot_cls = {4'(c2), 4'(c1), 4'(c0)};
        eg = '0; el = '0; alive = !r;
        nm = 0; nw = 0; ns = 0; nf = 0; nd = 0; md_occ = 0;
        for (int i = 0; i < 3; i++) begin
            bit m, w, s, f, d, ok;
            int o, l;
            cls_info(cs[i], m, w, s, f, d, o, l);
            ok = alive && v[i];
            if (m && nm >= 1) ok = 0;
            if (w && nw >= 2) ok = 0;
            if (s && ns >= 1) ok = 0;
            if (f && nf >= 1) ok = 0;
            if (d && (nd >= 1 || cyc < free_at)) ok = 0;
            if (ok) begin
                eg[i] = 1;
                el[i*4 +: 4] = 4'(l);
                nm += int'(m); nw += int'(w); ns += int'(s); nf += int'(f);
                if (d) begin nd++; md_occ = o; end
            end else begin
                alive = 0;
            end
        end
        @(negedge clk);
        check({tag, " grant"}, {9'd0, grant}, {9'd0, eg});
        check({tag, " R8/R9 latency"}, lat, el);
        if (r) free_at = 0;
        else if (nd != 0) free_at = cyc + md_occ;
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: nothing granted in reset, even resource-free classes
        step("R1", 1, 3'b111, 0, 12, 10);
        step("R1", 1, 3'b111, 10, 0, 0);
        // R1: first cycle after reset the shared unit is idle
        step("R1", 0, 3'b001, 10, 0, 0);
        // R7: square root holds the shared unit for 10 cycles
        for (int k = 0; k < 10; k++) step("R7", 0, 3'b001, 7, 0, 0);
        // R7: FP multiply occupies one cycle: back-to-back accepted
        step("R7", 0, 3'b001, 7, 0, 0);
        // R7: two shared ops in one cycle: only the older one
        step("R7", 0, 3'b011, 11, 7, 0);
        for (int k = 0; k < 5; k++) step("R7", 0, 3'b001, 8, 0, 0);
        for (int k = 0; k < 5; k++) step("R7", 0, 3'b001, 9, 0, 0);
        for (int k = 0; k < 8; k++) step("R7", 0, 3'b010, 0, 9, 0);
        // R3: one memory op per cycle
        step("R3", 0, 3'b111, 2, 5, 0);
        step("R3", 0, 3'b111, 4, 3, 0);
        step("R3", 0, 3'b111, 0, 5, 4);
        // R4: two integer write ports
        step("R4", 0, 3'b111, 0, 1, 3);
        step("R4", 0, 3'b111, 0, 0, 0);
        step("R4", 0, 3'b111, 0, 4, 5);
        // R5: one shifter
        step("R5", 0, 3'b111, 1, 1, 6);
        step("R5", 0, 3'b111, 6, 1, 1);
        // R6: one FP adder, free again next cycle
        step("R6", 0, 3'b111, 6, 6, 0);
        step("R6", 0, 3'b001, 6, 0, 0);
        // R2: invalid slot stops younger slots
        step("R2", 0, 3'b101, 0, 0, 0);
        step("R2", 0, 3'b110, 0, 0, 0);
        // R8: latency of each class
        for (int c = 0; c < 12; c++) begin
            step("R8", 0, 3'b001, c, 0, 0);
            repeat (12) step("R8", 0, 3'b000, 0, 0, 0);
        end
        // R9: refused younger slots read zero latency
        step("R9", 0, 3'b111, 6, 6, 10);
        // R10: reserved codes take no resource and report zero latency
        step("R10", 0, 3'b111, 13, 1, 1);
        step("R10", 0, 3'b111, 2, 15, 12);
        // R2: random mixes against the model
        for (int k = 0; k < 400; k++) begin
            step("R2 random", 0, 3'($urandom_range(0, 7)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 15)));
        end
        // R1: reset mid-stream clears shared busy state
        step("R1", 0, 3'b001, 10, 0, 0);
        step("R1", 1, 3'b000, 0, 0, 0);
        step("R1", 0, 3'b001, 9, 0, 0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule